// File: doc/BRIEF.md
# Zero-Operand Stack Processor Core

This block is a small processor that evaluates expressions on an on-chip LIFO of 16-bit words. Most instructions are a single byte with no operand field; the operands of arithmetic and logic come implicitly from the top two stack entries, and the result replaces them. A second LIFO, kept apart from the data stack, holds return addresses for subroutine calls.

Program bytes arrive from a synchronous instruction ROM: the address is presented in one cycle and the byte is returned after the next clock edge. A single data memory port serves load and store, taking its address from the top of the data stack. A small sequencer steps each instruction through fetch, execute and, for instructions that carry an argument byte, a second fetch. Any stack fault stops the core and leaves a code on a sticky fault output. A halt instruction stops it cleanly and raises `done`, so the caller can read the final top of stack.

Instruction bytes hold a class in bits [7:6] and an operation number in bits [5:0]. Instructions that carry an argument are followed by one byte holding an 8-bit immediate or an absolute branch target.

Top module: `smc_core`

## Requirements
- R1: Class 0 operations pop two entries and push one result, with the former top as right operand and the entry beneath it as left: 0x00 add, 0x01 subtract (left minus right), 0x02 AND, 0x03 OR, 0x04 XOR, 0x05 unsigned less-than (result 1 or 0).
- R2: Byte 0x80 followed by an argument byte pushes that byte zero-extended to 16 bits.
- R3: 0x40 duplicates the top, 0x41 exchanges the top two, 0x42 discards the top, 0x43 pushes a copy of the entry beneath the top.
- R4: 0x44 replaces the top with the memory word at address top[7:0]; 0x45 writes the entry beneath the top to address top[7:0] and pops both.
- R5: 0x81 with a target byte jumps unconditionally; 0x82 with a target byte pops the top and jumps only when that value is zero, otherwise continues after the argument byte.
- R6: 0x83 with a target byte pushes the address after its argument byte onto the return stack, leaves the data stack alone, and jumps; 0x46 pops the return stack into the program counter.
- R7: 0x47 stops the core: `done` goes high and stays high, the instruction address and `top_value` stop changing.
- R8: An instruction needing more entries than the data stack holds sets `fault` to 01, stops the core with `done` high and leaves the stack unchanged.
- R9: An instruction that would leave more than 16 entries on the data stack sets `fault` to 10 and stops the core with the stack unchanged.
- R10: A call with 8 return addresses already held, or a return with none held, sets `fault` to 11 and stops the core.
- R11: Reset gives instruction address 0, `done` low, `fault` 00 and `top_value` 0; a nonzero fault code holds until reset.
- R12: Bytes of class 3 and unassigned operation numbers in classes 0 to 2 change no state except advancing the program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 8 | Instruction ROM address (program counter) |
| imem_data | input | 8 | ROM byte, registered one clock after its address |
| dmem_addr | output | 8 | Data memory address, low byte of the top entry |
| dmem_wdata | output | 16 | Store data, the entry beneath the top |
| dmem_we | output | 1 | Store strobe |
| dmem_rdata | input | 16 | Data memory read word, registered one clock after its address |
| top_value | output | 16 | Current top of the data stack, 0 when empty |
| done | output | 1 | Core has stopped, by halt or by fault |
| fault | output | 2 | Sticky fault code: 00 none, 01 underflow, 10 overflow, 11 return stack |

## Verification
A plain instruction takes two cycles (fetch, execute), an instruction with an argument byte four, and a load three, with the stack updating at the clock edge that ends the execute step. Since every result is only defined once the program reaches its halt or fault, the bench never counts cycles to a result: it runs each program until `done` rises, then samples `top_value`, `fault` and `imem_addr` at the following falling edge, and for the frozen-state rule samples again several cycles later. Expected tops are computed by a bench-side stack model for random programs and by hand for the directed ones.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [3:0] {
        K_NOP, K_ALU, K_DUP, K_SWAP, K_DROP, K_OVER, K_LOAD,
        K_STORE, K_RET, K_HALT, K_PUSH, K_JMP, K_JZ, K_CALL
    } kind_e;

    typedef enum logic [2:0] {
        A_ADD, A_SUB, A_AND, A_OR, A_XOR, A_LTU
    } alu_e;

    typedef enum logic [2:0] {
        S_FETCH, S_EXEC, S_ARGW, S_ARG, S_LOADW, S_STOP
    } state_e;

    typedef struct packed {
        kind_e      kind;
        alu_e       alu;
        logic       has_arg;
        logic [1:0] need;
        logic [1:0] pops;
        logic [1:0] pushes;
    } dec_t;

    localparam logic [1:0] CL_ALU = 2'd0;
    localparam logic [1:0] CL_STK = 2'd1;
    localparam logic [1:0] CL_ARG = 2'd2;

    localparam logic [1:0] FLT_NONE  = 2'b00;
    localparam logic [1:0] FLT_UNDER = 2'b01;
    localparam logic [1:0] FLT_OVER  = 2'b10;
    localparam logic [1:0] FLT_RET   = 2'b11;

    function automatic dec_t effect(kind_e k, alu_e a, logic arg,
                                    int need, int pops, int pushes);
        dec_t d;
        d.kind    = k;
        d.alu     = a;
        d.has_arg = arg;
        d.need    = 2'(need);
        d.pops    = 2'(pops);
        d.pushes  = 2'(pushes);
        return d;
    endfunction

endpackage

// File: rtl/smc_decode.sv
module smc_decode
    import smc_pkg::*;
(
    input  logic [7:0] op_byte,
    output dec_t       dec
);
    logic [1:0] cls;
    logic [5:0] op;

    assign cls = op_byte[7:6];
    assign op  = op_byte[5:0];

    always_comb begin
        dec = effect(K_NOP, A_ADD, 1'b0, 0, 0, 0);
        unique case (cls)
            CL_ALU: begin
                case (op)
                    6'd0: dec = effect(K_ALU, A_ADD, 1'b0, 2, 2, 1);
                    6'd1: dec = effect(K_ALU, A_SUB, 1'b0, 2, 2, 1);
                    6'd2: dec = effect(K_ALU, A_AND, 1'b0, 2, 2, 1);
                    6'd3: dec = effect(K_ALU, A_OR,  1'b0, 2, 2, 1);
                    6'd4: dec = effect(K_ALU, A_XOR, 1'b0, 2, 2, 1);
                    6'd5: dec = effect(K_ALU, A_LTU, 1'b0, 2, 2, 1);
                    default: ;
                endcase
            end
            CL_STK: begin
                case (op)
                    6'd0: dec = effect(K_DUP,   A_ADD, 1'b0, 1, 0, 1);
                    6'd1: dec = effect(K_SWAP,  A_ADD, 1'b0, 2, 2, 2);
                    6'd2: dec = effect(K_DROP,  A_ADD, 1'b0, 1, 1, 0);
                    6'd3: dec = effect(K_OVER,  A_ADD, 1'b0, 2, 0, 1);
                    6'd4: dec = effect(K_LOAD,  A_ADD, 1'b0, 1, 1, 0);
                    6'd5: dec = effect(K_STORE, A_ADD, 1'b0, 2, 2, 0);
                    6'd6: dec = effect(K_RET,   A_ADD, 1'b0, 0, 0, 0);
                    6'd7: dec = effect(K_HALT,  A_ADD, 1'b0, 0, 0, 0);
                    default: ;
                endcase
            end
            CL_ARG: begin
                case (op)
                    6'd0: dec = effect(K_PUSH, A_ADD, 1'b1, 0, 0, 1);
                    6'd1: dec = effect(K_JMP,  A_ADD, 1'b1, 0, 0, 0);
                    6'd2: dec = effect(K_JZ,   A_ADD, 1'b1, 1, 1, 0);
                    6'd3: dec = effect(K_CALL, A_ADD, 1'b1, 0, 0, 0);
                    default: ;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/smc_alu.sv
module smc_alu
    import smc_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_e         op,
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            A_ADD:   y = lhs + rhs;
            A_SUB:   y = lhs - rhs;
            A_AND:   y = lhs & rhs;
            A_OR:    y = lhs | rhs;
            A_XOR:   y = lhs ^ rhs;
            A_LTU:   y = {{(W-1){1'b0}}, (lhs < rhs)};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/smc_stack.sv
module smc_stack #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    parameter int NRD   = 2,
    parameter int NWR   = 2,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic [1:0]             pop_n,
    input  logic [1:0]             push_n,
    input  logic [NWR-1:0][W-1:0]  wr,
    output logic [DW-1:0]          depth,
    output logic [NRD-1:0][W-1:0]  rd
);
    logic [W-1:0]  cells [DEPTH];
    logic [DW-1:0] base;

    assign base = depth - DW'(pop_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            depth <= '0;
        end else if (en) begin
            depth <= base + DW'(push_n);
        end
    end

    always_ff @(posedge clk) begin
        if (en) begin
            for (int i = 0; i < DEPTH; i++) begin
                for (int k = 0; k < NWR; k++) begin
                    if (int'(push_n) > k && base + DW'(k) == DW'(i)) begin
                        cells[i] <= wr[k];
                    end
                end
            end
        end
    end

    generate
        for (genvar k = 0; k < NRD; k++) begin : g_rd
            always_comb begin
                rd[k] = '0;
                for (int i = 0; i < DEPTH; i++) begin
                    if (DW'(i + k + 1) == depth) begin
                        rd[k] = cells[i];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/smc_core.sv
module smc_core
    import smc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int IW   = 8,
    parameter int PCW  = 8,
    parameter int AW   = 8,
    parameter int DSD  = 16,
    parameter int RSD  = 8
) (
    input  logic           clk,
    input  logic           rst,
    output logic [PCW-1:0] imem_addr,
    input  logic [IW-1:0]  imem_data,
    output logic [AW-1:0]  dmem_addr,
    output logic [DW-1:0]  dmem_wdata,
    output logic           dmem_we,
    input  logic [DW-1:0]  dmem_rdata,
    output logic [DW-1:0]  top_value,
    output logic           done,
    output logic [1:0]     fault
);
    localparam int DDW = $clog2(DSD + 1);
    localparam int RDW = $clog2(RSD + 1);

    state_e          state;
    logic [PCW-1:0]  pc;
    logic [IW-1:0]   ir;
    logic [IW-1:0]   op_byte;
    dec_t            dec;
    logic            act;
    logic [1:0]      flt_now;
    logic            go;

    logic [DDW-1:0]          ds_depth;
    logic [1:0][DW-1:0]      ds_rd;
    logic [1:0][DW-1:0]      ds_wr;
    logic                    ds_en;
    logic [1:0]              ds_pop;
    logic [1:0]              ds_push;
    logic [DW-1:0]           alu_y;

    logic [RDW-1:0]          rs_depth;
    logic [0:0][PCW-1:0]     rs_rd;
    logic [0:0][PCW-1:0]     rs_wr;
    logic                    rs_en;
    logic [1:0]              rs_pop;
    logic [1:0]              rs_push;

    assign op_byte = (state == S_ARG) ? ir : imem_data;

    smc_decode u_dec (
        .op_byte (op_byte),
        .dec     (dec)
    );

    smc_alu #(.W(DW)) u_alu (
        .op  (dec.alu),
        .lhs (ds_rd[1]),
        .rhs (ds_rd[0]),
        .y   (alu_y)
    );

    assign act = (state == S_ARG) || (state == S_EXEC && !dec.has_arg);

    always_comb begin
        flt_now = FLT_NONE;
        if (int'(ds_depth) < int'(dec.need)) begin
            flt_now = FLT_UNDER;
        end else if (int'(ds_depth) - int'(dec.pops) + int'(dec.pushes) > DSD) begin
            flt_now = FLT_OVER;
        end else if ((dec.kind == K_CALL && int'(rs_depth) == RSD) ||
                     (dec.kind == K_RET && rs_depth == '0)) begin
            flt_now = FLT_RET;
        end
    end

    assign go = act && (flt_now == FLT_NONE);

    always_comb begin
        ds_wr = '0;
        unique case (dec.kind)
            K_ALU:   ds_wr[0] = alu_y;
            K_DUP:   ds_wr[0] = ds_rd[0];
            K_SWAP:  begin
                ds_wr[0] = ds_rd[0];
                ds_wr[1] = ds_rd[1];
            end
            K_OVER:  ds_wr[0] = ds_rd[1];
            K_PUSH:  ds_wr[0] = {{(DW-IW){1'b0}}, imem_data};
            default: ;
        endcase
        if (state == S_LOADW) begin
            ds_wr[0] = dmem_rdata;
        end
    end

    assign ds_en   = go || (state == S_LOADW);
    assign ds_pop  = (state == S_LOADW) ? 2'd0 : dec.pops;
    assign ds_push = (state == S_LOADW) ? 2'd1 : dec.pushes;

    smc_stack #(.W(DW), .DEPTH(DSD), .NRD(2), .NWR(2)) u_dstk (
        .clk    (clk),
        .rst    (rst),
        .en     (ds_en),
        .pop_n  (ds_pop),
        .push_n (ds_push),
        .wr     (ds_wr),
        .depth  (ds_depth),
        .rd     (ds_rd)
    );

    assign rs_en      = go && (dec.kind == K_CALL || dec.kind == K_RET);
    assign rs_pop     = (dec.kind == K_RET)  ? 2'd1 : 2'd0;
    assign rs_push    = (dec.kind == K_CALL) ? 2'd1 : 2'd0;
    assign rs_wr[0]   = pc + PCW'(1);

    smc_stack #(.W(PCW), .DEPTH(RSD), .NRD(1), .NWR(1)) u_rstk (
        .clk    (clk),
        .rst    (rst),
        .en     (rs_en),
        .pop_n  (rs_pop),
        .push_n (rs_push),
        .wr     (rs_wr),
        .depth  (rs_depth),
        .rd     (rs_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_FETCH;
            pc    <= '0;
            ir    <= '0;
            fault <= FLT_NONE;
        end else begin
            unique case (state)
                S_FETCH: state <= S_EXEC;
                S_EXEC: begin
                    if (dec.has_arg) begin
                        ir    <= imem_data;
                        pc    <= pc + PCW'(1);
                        state <= S_ARGW;
                    end else if (flt_now != FLT_NONE) begin
                        fault <= flt_now;
                        state <= S_STOP;
                    end else begin
                        unique case (dec.kind)
                            K_HALT: state <= S_STOP;
                            K_RET: begin
                                pc    <= rs_rd[0];
                                state <= S_FETCH;
                            end
                            K_LOAD: begin
                                pc    <= pc + PCW'(1);
                                state <= S_LOADW;
                            end
                            default: begin
                                pc    <= pc + PCW'(1);
                                state <= S_FETCH;
                            end
                        endcase
                    end
                end
                S_ARGW: state <= S_ARG;
                S_ARG: begin
                    if (flt_now != FLT_NONE) begin
                        fault <= flt_now;
                        state <= S_STOP;
                    end else begin
                        state <= S_FETCH;
                        unique case (dec.kind)
                            K_JMP:  pc <= PCW'(imem_data);
                            K_CALL: pc <= PCW'(imem_data);
                            K_JZ:   pc <= (ds_rd[0] == '0) ? PCW'(imem_data)
                                                           : pc + PCW'(1);
                            default: pc <= pc + PCW'(1);
                        endcase
                    end
                end
                S_LOADW: state <= S_FETCH;
                default: state <= S_STOP;
            endcase
        end
    end

    assign imem_addr  = pc;
    assign dmem_addr  = ds_rd[0][AW-1:0];
    assign dmem_wdata = ds_rd[1];
    assign dmem_we    = go && (dec.kind == K_STORE);
    assign top_value  = ds_rd[0];
    assign done       = (state == S_STOP);

endmodule

// File: rtl/smc_core_chk.sv
module smc_core_chk #(
    parameter int PCW = 8,
    parameter int DW  = 16
) (
    input logic           clk,
    input logic           rst,
    input logic [PCW-1:0] imem_addr,
    input logic           dmem_we,
    input logic [DW-1:0]  top_value,
    input logic           done,
    input logic [1:0]     fault
);
    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (fault != 2'b00) |=> (fault == $past(fault)));

    assert_done_holds_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(imem_addr));

    assert_top_frozen_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> $stable(top_value));

    assert_trap_stops_R8: assert property (@(posedge clk) disable iff (rst)
        (fault != 2'b00) |-> done);

    assert_no_store_when_stopped_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> !dmem_we);
endmodule

bind smc_core smc_core_chk #(.PCW(PCW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .imem_addr (imem_addr),
    .dmem_we   (dmem_we),
    .top_value (top_value),
    .done      (done),
    .fault     (fault)
);

// File: tb/smc_core_test.sv
`timescale 1ns/1ps
module smc_core_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  imem_addr;
    logic [7:0]  imem_data;
    logic [7:0]  dmem_addr;
    logic [15:0] dmem_wdata;
    logic        dmem_we;
    logic [15:0] dmem_rdata;
    logic [15:0] top_value;
    logic        done;
    logic [1:0]  fault;

    logic [7:0]  rom [256];
    logic [15:0] ram [256];
    int          wp;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          ended  = 0;

    always #4 clk = ~clk;

    always @(posedge clk) imem_data <= rom[imem_addr];
    always @(posedge clk) begin
        if (dmem_we) ram[dmem_addr] <= dmem_wdata;
        dmem_rdata <= ram[dmem_addr];
    end

    smc_core uut (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .top_value(top_value), .done(done), .fault(fault)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clear_rom();
        for (int i = 0; i < 256; i++) rom[i] = 8'h47;
        wp = 0;
    endtask

    task automatic put(input logic [7:0] b);
        rom[wp] = b;
        wp++;
    endtask

    task automatic run(input string req);
        int n;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n = 0;
        while (!done && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (!done) chk({req, " timeout"}, 32'(done), 32'd1);
    endtask

    task automatic expect_end(input string req, input logic [15:0] top, input logic [1:0] flt);
        run(req);
        chk(req, 32'(top_value), 32'(top));
        chk({req, " fault"}, 32'(fault), 32'(flt));
    endtask

    function automatic logic [15:0] model_alu(input int op, input logic [15:0] l, input logic [15:0] r);
        case (op)
            0: return l + r;
            1: return l - r;
            2: return l & r;
            3: return l | r;
            4: return l ^ r;
            default: return (l < r) ? 16'd1 : 16'd0;
        endcase
    endfunction

    task automatic random_prog(input int id);
        logic [15:0] stk [16];
        int d;
        int pick;
        logic [15:0] t;
        clear_rom();
        d = 0;
        t = 16'($urandom_range(0, 255));
        put(8'h80); put(t[7:0]); stk[0] = t; d = 1;
        for (int s = 0; s < 24; s++) begin
            pick = $urandom_range(0, 9);
            if (pick < 4 && d < 16) begin
                t = 16'($urandom_range(0, 255));
                put(8'h80); put(t[7:0]); stk[d] = t; d++;
            end else if (pick < 7 && d >= 2) begin
                int op;
                op = $urandom_range(0, 5);
                put(8'(op));
                stk[d-2] = model_alu(op, stk[d-2], stk[d-1]); d--;
            end else if (pick == 7 && d < 16) begin
                put(8'h40); stk[d] = stk[d-1]; d++;
            end else if (pick == 8 && d >= 2) begin
                put(8'h41); t = stk[d-1]; stk[d-1] = stk[d-2]; stk[d-2] = t;
            end else if (pick == 9 && d >= 2 && d < 16) begin
                put(8'h43); stk[d] = stk[d-2]; d++;
            end
        end
        put(8'h47);
        expect_end($sformatf("R1 R3 random program %0d", id), stk[d-1], 2'b00);
    endtask

    initial begin
        #1600000;
        if (!ended) begin
            ended = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [7:0] pc_snap;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) ram[i] = '0;

        // R11 reset state
        clear_rom();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 reset addr", 32'(imem_addr), 32'd0);
        chk("R11 reset done", 32'(done), 32'd0);
        chk("R11 reset fault", 32'(fault), 32'd0);
        chk("R11 reset top", 32'(top_value), 32'd0);

        // R1 operand order
        clear_rom(); put(8'h80); put(8'd9); put(8'h80); put(8'd4); put(8'h01); put(8'h47);
        expect_end("R1 subtract 9-4", 16'd5, 2'b00);
        clear_rom(); put(8'h80); put(8'd4); put(8'h80); put(8'd9); put(8'h01); put(8'h47);
        expect_end("R1 subtract 4-9", 16'hFFFB, 2'b00);
        clear_rom(); put(8'h80); put(8'd3); put(8'h80); put(8'd7); put(8'h05); put(8'h47);
        expect_end("R1 ltu 3<7", 16'd1, 2'b00);
        clear_rom(); put(8'h80); put(8'd7); put(8'h80); put(8'd3); put(8'h05); put(8'h47);
        expect_end("R1 ltu 7<3", 16'd0, 2'b00);

        // R2 zero extension; R7 frozen after halt
        clear_rom(); put(8'h80); put(8'hFF); put(8'h47);
        expect_end("R2 push 0xFF", 16'h00FF, 2'b00);
        chk("R7 halt addr", 32'(imem_addr), 32'd2);
        pc_snap = imem_addr;
        repeat (6) @(negedge clk);
        chk("R7 addr frozen", 32'(imem_addr), 32'(pc_snap));
        chk("R7 done held", 32'(done), 32'd1);
        chk("R7 top held", 32'(top_value), 32'h00FF);

        // R3 shuffles
        clear_rom(); put(8'h80); put(8'd1); put(8'h80); put(8'd2); put(8'h41); put(8'h47);
        expect_end("R3 swap", 16'd1, 2'b00);
        clear_rom(); put(8'h80); put(8'd1); put(8'h80); put(8'd2); put(8'h41); put(8'h42); put(8'h47);
        expect_end("R3 swap drop", 16'd2, 2'b00);
        clear_rom(); put(8'h80); put(8'd5); put(8'h80); put(8'd6); put(8'h43); put(8'h47);
        expect_end("R3 over", 16'd5, 2'b00);
        clear_rom(); put(8'h80); put(8'd21); put(8'h40); put(8'h00); put(8'h47);
        expect_end("R3 dup add", 16'd42, 2'b00);

        // R4 memory
        clear_rom(); put(8'h80); put(8'hAB); put(8'h80); put(8'h10); put(8'h45);
        put(8'h80); put(8'h10); put(8'h44); put(8'h47);
        expect_end("R4 store then load", 16'h00AB, 2'b00);
        clear_rom(); put(8'h80); put(8'd1); put(8'h80); put(8'h5C); put(8'h80); put(8'h11);
        put(8'h45); put(8'h47);
        expect_end("R4 store pops both", 16'd1, 2'b00);
        chk("R4 ram written", 32'(ram[8'h11]), 32'h005C);

        // R5 branches
        clear_rom(); put(8'h80); put(8'd0); put(8'h82); put(8'd7); put(8'h80); put(8'd99);
        put(8'h47); put(8'h80); put(8'd7); put(8'h47);
        expect_end("R5 jz taken", 16'd7, 2'b00);
        clear_rom(); put(8'h80); put(8'd5); put(8'h82); put(8'd7); put(8'h80); put(8'd99);
        put(8'h47); put(8'h80); put(8'd7); put(8'h47);
        expect_end("R5 jz not taken", 16'd99, 2'b00);
        clear_rom(); put(8'h80); put(8'd3); put(8'h80); put(8'd0); put(8'h82); put(8'd6); put(8'h47);
        expect_end("R5 jz pops zero", 16'd3, 2'b00);
        clear_rom(); put(8'h80); put(8'd3); put(8'h80); put(8'd1); put(8'h82); put(8'd8); put(8'h47);
        expect_end("R5 jz pops nonzero", 16'd3, 2'b00);
        clear_rom(); put(8'h81); put(8'd4); put(8'h80); put(8'd1); put(8'h80); put(8'd2);
        put(8'h00); put(8'h47);
        expect_end("R5 jmp skips push", 16'd2, 2'b01);

        // R6 call and return
        clear_rom(); put(8'h80); put(8'd4); put(8'h83); put(8'd8); put(8'h80); put(8'd1);
        put(8'h00); put(8'h47); put(8'h80); put(8'd10); put(8'h00); put(8'h46);
        expect_end("R6 call ret", 16'd15, 2'b00);

        // R8 underflow
        clear_rom(); put(8'h80); put(8'd5); put(8'h00); put(8'h47);
        expect_end("R8 add on one entry", 16'd5, 2'b01);
        clear_rom(); put(8'h42);
        expect_end("R8 drop on empty", 16'd0, 2'b01);
        chk("R8 done on fault", 32'(done), 32'd1);

        // R9 overflow
        clear_rom();
        for (int i = 1; i <= 17; i++) begin put(8'h80); put(8'(i)); end
        expect_end("R9 seventeenth push", 16'd16, 2'b10);
        repeat (4) @(negedge clk);
        chk("R11 fault sticky", 32'(fault), 32'd2);

        // R10 return stack
        clear_rom(); put(8'h46);
        expect_end("R10 ret empty", 16'd0, 2'b11);
        clear_rom(); put(8'h83); put(8'd0);
        expect_end("R10 call depth nine", 16'd0, 2'b11);

        // R12 undefined bytes
        clear_rom(); put(8'hC5); put(8'h3F); put(8'h7E); put(8'h80); put(8'd3); put(8'h47);
        expect_end("R12 undefined ignored", 16'd3, 2'b00);
        chk("R12 address after", 32'(imem_addr), 32'd5);

        // random programs
        for (int p = 0; p < 40; p++) random_prog(p);

        if (!ended) begin
            ended = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule